// File: doc/BRIEF.md
# Core-local timer and software interrupt unit

This block gives a single hart its machine timer and its software interrupt. It holds a 64-bit time counter that runs freely, a 64-bit compare value and one software interrupt bit. All three sit inside a 64 KiB address window and are reached through a simple byte-wide bus. Two interrupt outputs go straight to the hart's pending register. The low 32 bits of the counter are also brought out on their own port, so that a read-only time register elsewhere can read them.

Each 64-bit register appears as eight bytes in little-endian order. A byte write updates one 8-bit lane and leaves every other lane alone. The counter steps once for each cycle in which `tick_i` is high. A bus write to any counter byte takes precedence over that step. The timer interrupt is armed only while both 32-bit halves of the compare value are non-zero.

Top module: `core_timer_irq`

## Requirements
- R1: After reset, the counter, the compare value and the software bit are all zero. Both interrupt outputs are low and `time_lo_o` is zero.
- R2: The software bit is bit 0 of the byte at offset 0x0000. `sw_irq_o` takes its new value in the cycle after the write. Offsets 0x0001 to 0x0003 read as zero and ignore writes.
- R3: The compare value occupies offsets 0x4000 to 0x4007. Offset 0x4000+k holds bits 8k+7 to 8k.
- R4: The time counter occupies offsets 0xBFF8 to 0xBFFF. Offset 0xBFF8+k holds bits 8k+7 to 8k.
- R5: A byte write changes only the addressed 8-bit lane of the register it targets.
- R6: The counter adds one at every clock edge where `tick_i` is high. When the low word wraps from 0xFFFFFFFF to zero, the high word adds one.
- R7: When a bus write to a counter byte meets a tick in the same cycle, the written byte is stored and the counter does not step in that cycle.
- R8: `tmr_irq_o` is high exactly when both compare halves are non-zero and the counter, taken as an unsigned 64-bit value, is greater than or equal to the compare value.
- R9: `time_lo_o` always equals bits 31 to 0 of the counter. The block offers no write path through that port.
- R10: Any read of an offset not listed in R2 to R4 returns zero, and a write to such an offset changes nothing.
- R11: `bus_rdata_o` returns the addressed byte combinationally while `bus_en_i` is high and `bus_we_i` is low. At all other times it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter step enable |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte offset within the window |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 8 | Read byte |
| sw_irq_o | output | 1 | Software interrupt |
| tmr_irq_o | output | 1 | Timer interrupt |
| time_lo_o | output | 32 | Low counter word for the time register |

## Verification
The hardest cases to reach are the carry from the low word into the high word and a timer comparison that the high words decide. With free ticking, either would take billions of cycles. The stimulus therefore writes the counter bytes directly: it places the low word just below the wrap point, and it sets up a counter whose high word exceeds the compare high word while its low word is smaller. It also clears a single compare half to check that the timer disarms. A cycle-level reference model is compared with every output on every clock. It runs through directed sequences and then a long run of random bus traffic with random ticks, in which byte writes meet ticks on the same edge.

// File: rtl/core_timer_pkg.sv
package core_timer_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned LANES    = REG_W / 8;
  localparam int unsigned LANE_W   = $clog2(LANES);
  localparam logic [ADDR_W-1:0] OFF_SW   = 16'h0000;
  localparam logic [ADDR_W-1:0] OFF_CMP  = 16'h4000;
  localparam logic [ADDR_W-1:0] OFF_TIME = 16'hBFF8;
endpackage

// File: rtl/core_timer_lane_reg.sv
module core_timer_lane_reg #(
  parameter int unsigned WIDTH = 64,
  parameter bit          COUNT = 1'b0
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          wr_en_i,
  input  logic [((WIDTH/8) > 1 ? $clog2(WIDTH/8) : 1)-1:0] wr_lane_i,
  input  logic [7:0]                                    wr_byte_i,
  input  logic                                          inc_i,
  output logic [WIDTH-1:0]                              q_o
);
  localparam int unsigned LANES = WIDTH / 8;
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] inc_val;

  generate
    if (COUNT) begin : g_count
      assign inc_val = q + WIDTH'(1);
    end else begin : g_hold
      assign inc_val = q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en_i) begin
          if (wr_lane_i == SEL_W'(l)) q[l*8 +: 8] <= wr_byte_i;
        end else if (inc_i) begin
          q[l*8 +: 8] <= inc_val[l*8 +: 8];
        end
      end
    end
  end

  assign q_o = q;

  // R5
  lane_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> q[$past(wr_lane_i)*8 +: 8] == $past(wr_byte_i));

  generate
    if (!COUNT) begin : g_hold_chk
      // R5
      hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/core_timer_cmp.sv
module core_timer_cmp #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] time_i,
  input  logic [WIDTH-1:0] cmp_i,
  output logic             irq_o
);
  localparam int unsigned HALF = WIDTH / 2;

  logic armed;
  assign armed = (|cmp_i[WIDTH-1:HALF]) && (|cmp_i[HALF-1:0]);
  assign irq_o = armed && (time_i >= cmp_i);
endmodule

// File: rtl/core_timer_irq.sv
module core_timer_irq
  import core_timer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        bus_en_i,
  input  logic        bus_we_i,
  input  logic [15:0] bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        sw_irq_o,
  output logic        tmr_irq_o,
  output logic [31:0] time_lo_o
);
  logic             hit_sw, hit_cmp, hit_time;
  logic             wr, rd;
  logic             sw_q;
  logic [REG_W-1:0] cmp_q, time_q;
  logic [LANE_W-1:0] lane;

  assign wr       = bus_en_i && bus_we_i;
  assign rd       = bus_en_i && !bus_we_i;
  assign lane     = bus_addr_i[LANE_W-1:0];
  assign hit_sw   = (bus_addr_i == OFF_SW);
  assign hit_cmp  = (bus_addr_i[ADDR_W-1:LANE_W] == OFF_CMP[ADDR_W-1:LANE_W]);
  assign hit_time = (bus_addr_i[ADDR_W-1:LANE_W] == OFF_TIME[ADDR_W-1:LANE_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sw_q <= 1'b0;
    else if (wr && hit_sw) sw_q <= bus_wdata_i[0];
  end

  core_timer_lane_reg #(.WIDTH(REG_W), .COUNT(1'b0)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr && hit_cmp),
    .wr_lane_i(lane),
    .wr_byte_i(bus_wdata_i),
    .inc_i    (1'b0),
    .q_o      (cmp_q)
  );

  core_timer_lane_reg #(.WIDTH(REG_W), .COUNT(1'b1)) u_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr && hit_time),
    .wr_lane_i(lane),
    .wr_byte_i(bus_wdata_i),
    .inc_i    (tick_i),
    .q_o      (time_q)
  );

  core_timer_cmp #(.WIDTH(REG_W)) u_cmp_eval (
    .time_i(time_q),
    .cmp_i (cmp_q),
    .irq_o (tmr_irq_o)
  );

  always_comb begin
    bus_rdata_o = 8'h00;
    if (rd) begin
      if (hit_sw)        bus_rdata_o = {7'b0, sw_q};
      else if (hit_cmp)  bus_rdata_o = cmp_q[lane*8 +: 8];
      else if (hit_time) bus_rdata_o = time_q[lane*8 +: 8];
    end
  end

  assign sw_irq_o  = sw_q;
  assign time_lo_o = time_q[31:0];

  // R2
  sw_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFF_SW) |=> sw_irq_o == $past(bus_wdata_i[0]));

  // R6
  time_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(wr && hit_time)) |=> time_q == $past(time_q) + REG_W'(1));

  // R8
  irq_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_irq_o |-> (time_q[REG_W-1:REG_W/2] >= cmp_q[REG_W-1:REG_W/2]) && (cmp_q != '0));
endmodule

// File: tb/sim_core_timer_irq.sv
module sim_core_timer_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_en_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        sw_irq_o, tmr_irq_o;
  logic [31:0] time_lo_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_time = '0;
  logic [63:0] m_cmp  = '0;
  logic        m_sw   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_timer_irq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .sw_irq_o(sw_irq_o), .tmr_irq_o(tmr_irq_o), .time_lo_o(time_lo_o)
  );

  function automatic logic [7:0] m_read(input logic [15:0] a);
    if (a == 16'h0000) return {7'b0, m_sw};
    if (a >= 16'h4000 && a <= 16'h4007) return m_cmp[(a - 16'h4000)*8 +: 8];
    if (a >= 16'hBFF8 && a <= 16'hBFFF) return m_time[(a - 16'hBFF8)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic m_irq();
    return (m_cmp[63:32] != 0) && (m_cmp[31:0] != 0) &&
           ((m_time[63:32] > m_cmp[63:32]) ||
            (m_time[63:32] == m_cmp[63:32] && m_time[31:0] >= m_cmp[31:0]));
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string req);
    check({req, " sw R2"}, 64'(sw_irq_o), 64'(m_sw));
    check({req, " tmr R8"}, 64'(tmr_irq_o), 64'(m_irq()));
    check({req, " time_lo R9"}, 64'(time_lo_o), 64'(m_time[31:0]));
  endtask

  // One bus cycle; inputs set after negedge, outputs compared after posedge.
  task automatic cyc(input bit en, input bit we, input logic [15:0] a,
                     input logic [7:0] d, input bit tk, input string req);
    logic [7:0] exp_rd;
    bus_en_i = en; bus_we_i = we; bus_addr_i = a; bus_wdata_i = d; tick_i = tk;
    #1;
    exp_rd = (en && !we) ? m_read(a) : 8'h00;
    check({req, " rdata R11"}, 64'(bus_rdata_o), 64'(exp_rd));
    @(posedge clk);
    if (en && we && a == 16'h0000) m_sw = d[0];
    if (en && we && a >= 16'h4000 && a <= 16'h4007) m_cmp[(a - 16'h4000)*8 +: 8] = d;
    if (en && we && a >= 16'hBFF8 && a <= 16'hBFFF) m_time[(a - 16'hBFF8)*8 +: 8] = d;
    else if (tk) m_time = m_time + 64'd1;
    #1;
    check_outs(req);
    @(negedge clk);
  endtask

  task automatic wr8(input logic [15:0] a, input logic [7:0] d, input string req);
    cyc(1, 1, a, d, 0, req);
  endtask

  task automatic rd8(input logic [15:0] a, input string req);
    cyc(1, 0, a, 8'h00, 0, req);
  endtask

  task automatic wr64(input logic [15:0] base, input logic [63:0] v, input string req);
    for (int k = 0; k < 8; k++) wr8(base + 16'(k), v[k*8 +: 8], req);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check_outs("R1 in reset");
    check("R1 rdata", 64'(bus_rdata_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) rd8(16'hBFF8 + 16'(k), "R1 time zero");
    for (int k = 0; k < 8; k++) rd8(16'h4000 + 16'(k), "R1 cmp zero");

    // R2
    wr8(16'h0000, 8'hFF, "R2 set");
    rd8(16'h0000, "R2 read");
    for (int k = 1; k < 4; k++) begin
      wr8(16'(k), 8'hFF, "R2 ignored byte");
      rd8(16'(k), "R2 ignored byte read");
    end
    wr8(16'h0000, 8'hFE, "R2 clear");

    // R3 R5
    wr64(16'h4000, 64'h8877_6655_4433_2211, "R3 cmp bytes");
    for (int k = 0; k < 8; k++) rd8(16'h4000 + 16'(k), "R3 readback");
    wr8(16'h4003, 8'hA5, "R5 single lane");
    for (int k = 0; k < 8; k++) rd8(16'h4000 + 16'(k), "R5 neighbours");

    // R4 R6
    wr64(16'hBFF8, 64'h0000_0000_FFFF_FFFD, "R4 time bytes");
    for (int k = 0; k < 6; k++) cyc(0, 0, 16'h0, 8'h0, 1, "R6 carry");
    for (int k = 0; k < 8; k++) rd8(16'hBFF8 + 16'(k), "R4 readback after carry");

    // R7
    cyc(1, 1, 16'hBFF9, 8'h77, 1, "R7 write beats tick");
    cyc(1, 1, 16'hBFF8, 8'hFF, 1, "R7 low lane write");
    cyc(0, 0, 16'h0, 8'h0, 1, "R7 step after");

    // R8 disarmed by a zero half
    wr64(16'h4000, 64'h0000_0000_0000_0005, "R8 cmp hi zero");
    wr64(16'hBFF8, 64'h0000_0009_0000_0009, "R8 time large");
    cyc(0, 0, 16'h0, 8'h0, 1, "R8 disarmed");
    wr64(16'h4000, 64'h0000_0001_0000_0005, "R8 arm");
    wr64(16'hBFF8, 64'h0000_0001_0000_0002, "R8 time below");
    for (int k = 0; k < 5; k++) cyc(0, 0, 16'h0, 8'h0, 1, "R8 crossing");
    wr64(16'hBFF8, 64'h0000_0002_0000_0001, "R8 hi decides");
    cyc(0, 0, 16'h0, 8'h0, 0, "R8 hi greater lo smaller");
    wr8(16'h4000, 8'h00, "R8 cmp lo zero");
    cyc(0, 0, 16'h0, 8'h0, 0, "R8 disarmed lo");

    // R10
    begin
      logic [15:0] un [6] = '{16'h0004, 16'h3FFF, 16'h4008, 16'hBFF7, 16'h1234, 16'hFFFF};
      foreach (un[i]) begin
        wr8(un[i], 8'hC3, "R10 unmapped write");
        rd8(un[i], "R10 unmapped read");
      end
    end
    cyc(0, 1, 16'h4001, 8'h5A, 0, "R11 no strobe");

    // Mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [15:0] a;
      r = $urandom;
      case (r[1:0])
        2'd0: a = {14'h0, r[3:2]};
        2'd1: a = 16'h4000 | 16'(r[4:2]);
        2'd2: a = 16'hBFF8 | 16'(r[4:2]);
        default: a = r[31:16];
      endcase
      cyc(r[5], r[6], a, r[15:8], r[7], "R5 R6 R7 R8 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule